// File: doc/BRIEF.md
# RTC Time Snapshot and Set Sequencer

This block drives a register-access port of an external serial real-time clock and turns whole-calendar requests into the right series of single-register transfers. The clock chip keeps its time fields in packed BCD and has two working copies of the time: a running counter and a holding copy. It also accepts address-only command transfers that copy one copy into the other. The bit-level serial link is not part of this block. It is reached through a request/done handshake that moves one register or one command at a time.

A host asks for one of three operations. A **read** takes a consistent snapshot of the running time and presents it as binary fields. A **set** loads binary fields into the clock. A **probe** checks that a chip answers and leaves its status register cleared. Only one operation runs at a time. The sequencer holds `req_ready` low until it pulses `op_done`.

Register addresses and the two command codes are parameters in the 4-bit address space. Month is zero-based on the binary side, and year is carried in an offset form.

Top module: `rtc_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `acc_req` is 0, `op_done` is 0 and `chip_present` is 0.
- R2: A request is accepted when `req_valid` and `req_ready` are both high. From the next cycle `req_ready` stays low until the cycle `op_done` is high. A request presented while busy has no effect: it causes no transfer and does not change the operation in progress.
- R3: A read (`req_op` = 00) first issues the latch command (`acc_cmd`=1, `acc_write`=1, address `CMD_LATCH`, default 0xE). It issues no register transfer before it.
- R4: After the latch, a read fetches seven registers in this order: seconds, minutes, hours, day of month, month, weekday, year. The default addresses are 0x2 to 0x8 in that order.
- R5: Each value fetched by a read is taken as two BCD digits (tens in bits 7:4, units in bits 3:0). It appears in binary on the matching `rd_*` output once `op_done` pulses.
- R6: `rd_mon` equals the fetched month minus one, and `rd_year` equals the fetched year plus 100.
- R7: A set (`req_op` = 01) writes the seven registers in the order given in R4. It then issues the commit command (`acc_cmd`=1, address `CMD_COMMIT`, default 0xF) as its last transfer.
- R8: A set writes the month as `wr_mon`+1 and the year as `wr_year` modulo 100, both in BCD. The other fields are written as their BCD value. The inputs are sampled in the cycle the request is accepted.
- R9: Any value above 99 that is to be written is clamped to BCD 0x99.
- R10: A probe (`req_op` = 1x) writes 0x33 to the seconds register and reads it back. If the read-back differs, the probe ends at once with `chip_present` = 0 and makes no further transfer.
- R11: If the probe read-back matches, the probe writes 0x00 to the status register (default address 0x0) and ends with `chip_present` = 1.
- R12: `acc_req` stays high with stable address, data, write and command fields until `acc_done`. `op_done` is a one-cycle pulse in the cycle after the final `acc_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Operation request |
| req_op | input | 2 | 00 read, 01 set, 1x probe |
| req_ready | output | 1 | High when idle and able to accept a request |
| wr_sec | input | 7 | Binary seconds to set |
| wr_min | input | 7 | Binary minutes to set |
| wr_hour | input | 7 | Binary hours to set |
| wr_mday | input | 7 | Binary day of month to set |
| wr_mon | input | 7 | Binary zero-based month to set |
| wr_wday | input | 7 | Binary weekday to set |
| wr_year | input | 8 | Binary year, reduced modulo 100 |
| rd_sec | output | 7 | Binary seconds from last transfer |
| rd_min | output | 7 | Binary minutes |
| rd_hour | output | 7 | Binary hours |
| rd_mday | output | 7 | Binary day of month |
| rd_mon | output | 7 | Binary zero-based month |
| rd_wday | output | 7 | Binary weekday |
| rd_year | output | 8 | Binary year plus 100 |
| op_done | output | 1 | One-cycle completion pulse |
| chip_present | output | 1 | Result of the last probe |
| acc_req | output | 1 | Register-access request, held until done |
| acc_cmd | output | 1 | Transfer is an address-only command |
| acc_write | output | 1 | Transfer writes (1) or reads (0) |
| acc_addr | output | 4 | Register or command address |
| acc_wdata | output | 8 | BCD data to write |
| acc_done | input | 1 | One-cycle completion of the current transfer |
| acc_rdata | input | 8 | Read data, valid with acc_done |

## Verification
The bench models the chip with a fixed two-cycle access latency and logs every transfer it starts. It compares that log with the order set by R3, R4, R7, R10 and R11. A request is accepted at the first rising edge where `req_valid` is high, so `req_ready` is sampled low on the falling edge that follows. The `rd_*` fields and `chip_present` are registered and are due in the cycle `op_done` is high, one cycle after the last `acc_done`. The bench therefore waits on falling edges for `op_done` and samples every result in that same half cycle. Register contents of the model are compared only after `op_done`, when all transfers have finished.

// File: rtl/rtc_seq_pkg.sv
package rtc_seq_pkg;
    localparam int DATA_W  = 8;
    localparam int NFIELD  = 7;
    localparam int STEP_W  = $clog2(NFIELD + 1);

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_SET   = 2'd1,
        OP_PROBE = 2'd2
    } op_e;

    typedef struct packed {
        logic                               busy;
        op_e                                op;
        logic [STEP_W-1:0]                  step;
        logic [NFIELD-1:0][DATA_W-1:0]      raw;
        logic                               present;
        logic                               done;
    } seq_state_t;

    // Two packed BCD digits to binary (0..165 for malformed digits).
    function automatic logic [DATA_W-1:0] bcd_to_bin(input logic [DATA_W-1:0] v);
        return DATA_W'(v[7:4]) * DATA_W'(10) + DATA_W'(v[3:0]);
    endfunction
endpackage

// File: rtl/rtc_bin2bcd.sv
module rtc_bin2bcd
    import rtc_seq_pkg::*;
(
    input  logic [DATA_W-1:0] bin,
    output logic [DATA_W-1:0] bcd
);
    localparam logic [DATA_W-1:0] LIMIT = DATA_W'(99);

    logic [DATA_W-1:0] clamped_d;
    logic [DATA_W-1:0] tens_d;
    logic [DATA_W-1:0] units_d;

    always_comb begin
        clamped_d = (bin > LIMIT) ? LIMIT : bin;
        tens_d    = clamped_d / DATA_W'(10);
        units_d   = clamped_d - tens_d * DATA_W'(10);
        bcd       = {tens_d[3:0], units_d[3:0]};
    end
endmodule

// File: rtl/rtc_step_plan.sv
module rtc_step_plan
    import rtc_seq_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] A_SEC    = 4'h2,
    parameter logic [ADDR_W-1:0] A_MIN    = 4'h3,
    parameter logic [ADDR_W-1:0] A_HOUR   = 4'h4,
    parameter logic [ADDR_W-1:0] A_MDAY   = 4'h5,
    parameter logic [ADDR_W-1:0] A_MON    = 4'h6,
    parameter logic [ADDR_W-1:0] A_WDAY   = 4'h7,
    parameter logic [ADDR_W-1:0] A_YEAR   = 4'h8,
    parameter logic [ADDR_W-1:0] A_STATUS = 4'h0,
    parameter logic [ADDR_W-1:0] CMD_LATCH  = 4'hE,
    parameter logic [ADDR_W-1:0] CMD_COMMIT = 4'hF,
    parameter logic [DATA_W-1:0] PROBE_PAT  = 8'h33
) (
    input  op_e                            op,
    input  logic [STEP_W-1:0]              step,
    input  logic [NFIELD-1:0][DATA_W-1:0]  raw,
    output logic [ADDR_W-1:0]              addr,
    output logic                           cmd,
    output logic                           write,
    output logic [DATA_W-1:0]              wdata,
    output logic                           last
);
    localparam logic [STEP_W-1:0] LAST_FULL  = STEP_W'(NFIELD);
    localparam logic [STEP_W-1:0] LAST_PROBE = STEP_W'(2);

    function automatic logic [ADDR_W-1:0] field_addr(input logic [STEP_W-1:0] idx);
        case (idx)
            STEP_W'(0): return A_SEC;
            STEP_W'(1): return A_MIN;
            STEP_W'(2): return A_HOUR;
            STEP_W'(3): return A_MDAY;
            STEP_W'(4): return A_MON;
            STEP_W'(5): return A_WDAY;
            default:    return A_YEAR;
        endcase
    endfunction

    logic [STEP_W-1:0] prev_d;

    always_comb begin
        prev_d = step - STEP_W'(1);
        addr   = '0;
        cmd    = 1'b0;
        write  = 1'b0;
        wdata  = '0;
        last   = 1'b0;
        case (op)
            OP_READ: begin
                last = (step == LAST_FULL);
                if (step == '0) begin
                    addr  = CMD_LATCH;
                    cmd   = 1'b1;
                    write = 1'b1;
                end else begin
                    addr = field_addr(prev_d);
                end
            end
            OP_SET: begin
                last = (step == LAST_FULL);
                if (step == LAST_FULL) begin
                    addr  = CMD_COMMIT;
                    cmd   = 1'b1;
                    write = 1'b1;
                end else begin
                    addr  = field_addr(step);
                    write = 1'b1;
                    wdata = raw[step[$clog2(NFIELD)-1:0]];
                end
            end
            default: begin
                last = (step == LAST_PROBE);
                if (step == '0) begin
                    addr  = A_SEC;
                    write = 1'b1;
                    wdata = PROBE_PAT;
                end else if (step == STEP_W'(1)) begin
                    addr = A_SEC;
                end else begin
                    addr  = A_STATUS;
                    write = 1'b1;
                end
            end
        endcase
    end
endmodule

// File: rtl/rtc_seq.sv
module rtc_seq
    import rtc_seq_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] A_SEC    = 4'h2,
    parameter logic [ADDR_W-1:0] A_MIN    = 4'h3,
    parameter logic [ADDR_W-1:0] A_HOUR   = 4'h4,
    parameter logic [ADDR_W-1:0] A_MDAY   = 4'h5,
    parameter logic [ADDR_W-1:0] A_MON    = 4'h6,
    parameter logic [ADDR_W-1:0] A_WDAY   = 4'h7,
    parameter logic [ADDR_W-1:0] A_YEAR   = 4'h8,
    parameter logic [ADDR_W-1:0] A_STATUS = 4'h0,
    parameter logic [ADDR_W-1:0] CMD_LATCH  = 4'hE,
    parameter logic [ADDR_W-1:0] CMD_COMMIT = 4'hF,
    parameter logic [DATA_W-1:0] PROBE_PAT  = 8'h33
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    output logic              req_ready,
    input  logic [6:0]        wr_sec,
    input  logic [6:0]        wr_min,
    input  logic [6:0]        wr_hour,
    input  logic [6:0]        wr_mday,
    input  logic [6:0]        wr_mon,
    input  logic [6:0]        wr_wday,
    input  logic [7:0]        wr_year,
    output logic [6:0]        rd_sec,
    output logic [6:0]        rd_min,
    output logic [6:0]        rd_hour,
    output logic [6:0]        rd_mday,
    output logic [6:0]        rd_mon,
    output logic [6:0]        rd_wday,
    output logic [7:0]        rd_year,
    output logic              op_done,
    output logic              chip_present,
    output logic              acc_req,
    output logic              acc_cmd,
    output logic              acc_write,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [DATA_W-1:0] acc_wdata,
    input  logic              acc_done,
    input  logic [DATA_W-1:0] acc_rdata
);
    localparam logic [DATA_W-1:0] YEAR_OFS = DATA_W'(100);
    localparam logic [DATA_W-1:0] YEAR_MOD = DATA_W'(100);

    seq_state_t state_d, state_q;

    // Binary-side write fields, month and year offset-adjusted.
    logic [NFIELD-1:0][DATA_W-1:0] enc_bin, enc_bcd;
    assign enc_bin[0] = DATA_W'(wr_sec);
    assign enc_bin[1] = DATA_W'(wr_min);
    assign enc_bin[2] = DATA_W'(wr_hour);
    assign enc_bin[3] = DATA_W'(wr_mday);
    assign enc_bin[4] = DATA_W'(wr_mon) + DATA_W'(1);
    assign enc_bin[5] = DATA_W'(wr_wday);
    assign enc_bin[6] = wr_year % YEAR_MOD;

    for (genvar gi = 0; gi < NFIELD; gi++) begin : g_enc
        rtc_bin2bcd u_enc (.bin(enc_bin[gi]), .bcd(enc_bcd[gi]));
    end

    logic step_last;

    rtc_step_plan #(
        .ADDR_W(ADDR_W), .A_SEC(A_SEC), .A_MIN(A_MIN), .A_HOUR(A_HOUR),
        .A_MDAY(A_MDAY), .A_MON(A_MON), .A_WDAY(A_WDAY), .A_YEAR(A_YEAR),
        .A_STATUS(A_STATUS), .CMD_LATCH(CMD_LATCH), .CMD_COMMIT(CMD_COMMIT),
        .PROBE_PAT(PROBE_PAT)
    ) u_plan (
        .op(state_q.op), .step(state_q.step), .raw(state_q.raw),
        .addr(acc_addr), .cmd(acc_cmd), .write(acc_write),
        .wdata(acc_wdata), .last(step_last)
    );

    always_comb begin
        state_d      = state_q;
        state_d.done = 1'b0;
        if (!state_q.busy) begin
            if (req_valid) begin
                state_d.busy = 1'b1;
                state_d.step = '0;
                state_d.op   = req_op[1] ? OP_PROBE : (req_op[0] ? OP_SET : OP_READ);
                if (!req_op[1] && req_op[0]) begin
                    state_d.raw = enc_bcd;
                end
            end
        end else if (acc_done) begin
            if (state_q.op == OP_READ && state_q.step != '0) begin
                state_d.raw[state_q.step - STEP_W'(1)] = acc_rdata;
            end
            if (state_q.op == OP_PROBE && state_q.step == STEP_W'(1)
                && acc_rdata != PROBE_PAT) begin
                state_d.busy    = 1'b0;
                state_d.done    = 1'b1;
                state_d.present = 1'b0;
            end else if (step_last) begin
                state_d.busy = 1'b0;
                state_d.done = 1'b1;
                if (state_q.op == OP_PROBE) begin
                    state_d.present = 1'b1;
                end
            end else begin
                state_d.step = state_q.step + STEP_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    logic [DATA_W-1:0] dec_sec, dec_min, dec_hour, dec_mday, dec_mon, dec_wday, dec_year;
    assign dec_sec  = bcd_to_bin(state_q.raw[0]);
    assign dec_min  = bcd_to_bin(state_q.raw[1]);
    assign dec_hour = bcd_to_bin(state_q.raw[2]);
    assign dec_mday = bcd_to_bin(state_q.raw[3]);
    assign dec_mon  = bcd_to_bin(state_q.raw[4]) - DATA_W'(1);
    assign dec_wday = bcd_to_bin(state_q.raw[5]);
    assign dec_year = bcd_to_bin(state_q.raw[6]) + YEAR_OFS;

    assign rd_sec       = dec_sec[6:0];
    assign rd_min       = dec_min[6:0];
    assign rd_hour      = dec_hour[6:0];
    assign rd_mday      = dec_mday[6:0];
    assign rd_mon       = dec_mon[6:0];
    assign rd_wday      = dec_wday[6:0];
    assign rd_year      = dec_year;
    assign req_ready    = !state_q.busy;
    assign acc_req      = state_q.busy;
    assign op_done      = state_q.done;
    assign chip_present = state_q.present;

    assert_busy_holdoff_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);
    assert_ready_at_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |-> req_ready);
    assert_cmd_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req && acc_cmd |-> acc_write && (acc_addr == CMD_LATCH || acc_addr == CMD_COMMIT));
    assert_bcd_digits_R9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req && acc_write && !acc_cmd |-> acc_wdata[7:4] <= 4'd9 && acc_wdata[3:0] <= 4'd9);
    assert_hold_transfer_R12: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req && !acc_done |=> acc_req && $stable(acc_addr) && $stable(acc_wdata)
                                  && $stable(acc_write) && $stable(acc_cmd));
    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> !op_done);
    assert_done_after_access_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(op_done) |-> $past(acc_done));
endmodule

// File: tb/rtc_seq_test.sv
module rtc_seq_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic       req_valid = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic       req_ready;
    logic [6:0] wr_sec = '0, wr_min = '0, wr_hour = '0, wr_mday = '0, wr_mon = '0, wr_wday = '0;
    logic [7:0] wr_year = '0;
    logic [6:0] rd_sec, rd_min, rd_hour, rd_mday, rd_mon, rd_wday;
    logic [7:0] rd_year;
    logic       op_done, chip_present;
    logic       acc_req, acc_cmd, acc_write;
    logic [3:0] acc_addr;
    logic [7:0] acc_wdata;
    logic       acc_done = 1'b0;
    logic [7:0] acc_rdata = '0;

    rtc_seq uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_ready(req_ready),
        .wr_sec(wr_sec), .wr_min(wr_min), .wr_hour(wr_hour), .wr_mday(wr_mday),
        .wr_mon(wr_mon), .wr_wday(wr_wday), .wr_year(wr_year),
        .rd_sec(rd_sec), .rd_min(rd_min), .rd_hour(rd_hour), .rd_mday(rd_mday),
        .rd_mon(rd_mon), .rd_wday(rd_wday), .rd_year(rd_year),
        .op_done(op_done), .chip_present(chip_present),
        .acc_req(acc_req), .acc_cmd(acc_cmd), .acc_write(acc_write), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .acc_done(acc_done), .acc_rdata(acc_rdata)
    );

    localparam logic [3:0] FA [7] = '{4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'h8};
    localparam logic [3:0] A_STAT = 4'h0, C_LATCH = 4'hE, C_COMMIT = 4'hF;

    // chip model: running and holding copies, transfer log {cmd,write,addr,wdata}
    logic [7:0]  run_r [16];
    logic [7:0]  hold_r [16];
    logic [13:0] xlog [32];
    int          log_n = 0;
    int          m_cnt = 0;
    logic        absent = 1'b0;

    always @(posedge clk) begin
        acc_done <= 1'b0;
        if (m_cnt != 0) begin
            m_cnt <= m_cnt - 1;
            if (m_cnt == 1) begin
                acc_done <= 1'b1;
                if (acc_cmd) begin
                    for (int i = 0; i < 16; i++) begin
                        if (acc_addr == C_LATCH) hold_r[i] <= run_r[i];
                        if (acc_addr == C_COMMIT) run_r[i] <= hold_r[i];
                    end
                end else if (acc_write) begin
                    hold_r[acc_addr] <= acc_wdata;
                end else begin
                    acc_rdata <= absent ? 8'hFF : hold_r[acc_addr];
                end
            end
        end else if (acc_req && !acc_done) begin
            m_cnt <= 2;
            if (log_n < 32) xlog[log_n] <= {acc_cmd, acc_write, acc_addr, acc_wdata};
            log_n <= log_n + 1;
        end
    end

    int checks = 0, failures = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int bcd2int(input logic [7:0] v);
        return int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction

    task automatic start_op(input logic [1:0] op);
        @(negedge clk);
        req_valid = 1'b1;
        req_op = op;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!op_done && n < 500) begin
            @(negedge clk);
            n++;
        end
        check(op_done == 1'b1, "R12 op_done seen", int'(op_done), 1);
    endtask

    task automatic clear_log();
        @(negedge clk);
        log_n = 0;
    endtask

    // inputs sec,min,hour,mday,mon,wday,year ; expected stored BCD in same order
    localparam logic [13:0][7:0] VEC [3] = '{
        {8'd5, 8'd59, 8'd23, 8'd31, 8'd11, 8'd6, 8'd24,
         8'h05, 8'h59, 8'h23, 8'h31, 8'h12, 8'h06, 8'h24},
        {8'd0, 8'd0, 8'd0, 8'd1, 8'd0, 8'd0, 8'd200,
         8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00},
        {8'd120, 8'd45, 8'd12, 8'd15, 8'd5, 8'd3, 8'd99,
         8'h99, 8'h45, 8'h12, 8'h15, 8'h06, 8'h03, 8'h99}
    };

    initial begin
        for (int i = 0; i < 16; i++) begin
            run_r[i] = 8'h00;
            hold_r[i] = 8'h00;
        end
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1 && acc_req == 1'b0, "R1 reset ready/acc_req",
              int'({req_ready, acc_req}), 2);
        check(op_done == 1'b0 && chip_present == 1'b0, "R1 reset done/present",
              int'({op_done, chip_present}), 0);
        rst_n = 1'b1;

        for (int v = 0; v < 3; v++) begin
            logic [13:0][7:0] e;
            e = VEC[v];
            wr_sec = e[13][6:0]; wr_min = e[12][6:0]; wr_hour = e[11][6:0];
            wr_mday = e[10][6:0]; wr_mon = e[9][6:0]; wr_wday = e[8][6:0];
            wr_year = e[7];
            clear_log();
            start_op(2'b01);
            wr_sec = 7'd77;
            wait_done();
            check(log_n == 8, "R7 set transfer count", log_n, 8);
            for (int k = 0; k < 7; k++) begin
                check(xlog[k] == {1'b0, 1'b1, FA[k], e[6 - k]}, "R7 R8 R9 set write order/data",
                      int'(xlog[k]), int'({1'b0, 1'b1, FA[k], e[6 - k]}));
                check(run_r[FA[k]] == e[6 - k], "R8 R9 committed BCD",
                      int'(run_r[FA[k]]), int'(e[6 - k]));
            end
            check(xlog[7][13:12] == 2'b11 && xlog[7][11:8] == C_COMMIT, "R7 commit last",
                  int'(xlog[7][13:8]), int'({2'b11, C_COMMIT}));
            // stale holding copy: only a latched read returns the running time
            for (int i = 0; i < 16; i++) hold_r[i] = 8'h77;
            clear_log();
            start_op(2'b00);
            wait_done();
            check(log_n == 8, "R3 R4 read transfer count", log_n, 8);
            check(xlog[0][13:12] == 2'b11 && xlog[0][11:8] == C_LATCH, "R3 latch first",
                  int'(xlog[0][13:8]), int'({2'b11, C_LATCH}));
            for (int k = 0; k < 7; k++)
                check(xlog[k + 1][13:8] == {2'b00, FA[k]}, "R4 read order",
                      int'(xlog[k + 1][13:8]), int'({2'b00, FA[k]}));
            check(int'(rd_sec) == bcd2int(e[6]), "R5 rd_sec", int'(rd_sec), bcd2int(e[6]));
            check(int'(rd_min) == bcd2int(e[5]), "R5 rd_min", int'(rd_min), bcd2int(e[5]));
            check(int'(rd_hour) == bcd2int(e[4]), "R5 rd_hour", int'(rd_hour), bcd2int(e[4]));
            check(int'(rd_mday) == bcd2int(e[3]), "R5 rd_mday", int'(rd_mday), bcd2int(e[3]));
            check(int'(rd_wday) == bcd2int(e[1]), "R5 rd_wday", int'(rd_wday), bcd2int(e[1]));
            check(int'(rd_mon) == bcd2int(e[2]) - 1, "R6 rd_mon", int'(rd_mon), bcd2int(e[2]) - 1);
            check(int'(rd_year) == bcd2int(e[0]) + 100, "R6 rd_year",
                  int'(rd_year), bcd2int(e[0]) + 100);
        end

        // R2: request while busy is ignored
        run_r[FA[0]] = 8'h42;
        clear_log();
        start_op(2'b00);
        repeat (2) @(negedge clk);
        check(req_ready == 1'b0, "R2 ready low while busy", int'(req_ready), 0);
        req_valid = 1'b1; req_op = 2'b01; wr_sec = 7'd9;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done();
        repeat (10) @(negedge clk);
        check(log_n == 8, "R2 no extra transfers", log_n, 8);
        check(run_r[FA[0]] == 8'h42, "R2 running time untouched", int'(run_r[FA[0]]), 'h42);
        check(rd_sec == 7'd42, "R2 read unaffected", int'(rd_sec), 42);

        // R10 R11: probe with a responding chip
        clear_log();
        start_op(2'b10);
        wait_done();
        check(chip_present == 1'b1, "R11 present", int'(chip_present), 1);
        check(log_n == 3, "R11 probe transfer count", log_n, 3);
        check(xlog[0] == {2'b01, FA[0], 8'h33}, "R10 pattern write", int'(xlog[0]),
              int'({2'b01, FA[0], 8'h33}));
        check(xlog[1][13:8] == {2'b00, FA[0]}, "R10 read-back", int'(xlog[1][13:8]),
              int'({2'b00, FA[0]}));
        check(xlog[2] == {2'b01, A_STAT, 8'h00}, "R11 status clear", int'(xlog[2]),
              int'({2'b01, A_STAT, 8'h00}));

        // R10: probe with no chip answering
        absent = 1'b1;
        clear_log();
        start_op(2'b11);
        wait_done();
        repeat (8) @(negedge clk);
        check(chip_present == 1'b0, "R10 absent", int'(chip_present), 0);
        check(log_n == 2, "R10 stops after mismatch", log_n, 2);
        check(req_ready == 1'b1, "R2 ready after probe", int'(req_ready), 1);
        absent = 1'b0;

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule